// File: doc/BRIEF.md
# Bus Handshake Protocol Monitor

This block sits passively on a shared parallel bus with a frame/ready handshake. It watches the initiator's frame and ready lines and the target's ready, stop and select lines, and samples them only on the rising clock edge. It does not drive the bus.

From these lines it works out which phase each clock cycle belongs to: idle, address or data. It emits a strobe for every data word that moves and keeps a count of the words moved in the current transaction. It also enforces the commitment rules of the handshake. Once the initiator has raised its ready line, it may not change ready or frame until the data phase ends. Once the target has raised its ready or stop line, it may not change select, ready or stop until the data phase ends. The initiator may also not drop frame while its ready line is low.

Each kind of violation latches its own error bit. All outputs are registered, so an output describes the cycle sampled at the most recent rising edge. Every bus input is active high: 1 means asserted.

Top module: `bus_hs_monitor`

## Requirements
- R1: While reset (synchronous, active high) is held, and after it is released with the bus idle, the outputs read as follows: phase 0 (idle), strobe 0, count 0, error vector 0.
- R2: When the bus is idle and frame is sampled high, the phase output reads 1 (address) after that edge, and the count reads 0.
- R3: Every cycle of a transaction after the address cycle reads phase 2 (data). The first cycle sampled with both frame and initiator-ready low reads phase 0 (idle), and the bus is free again.
- R4: The strobe is high for exactly one cycle after each data-phase cycle with both initiator-ready and target-ready high. A cycle where either of them is low is a wait and gives no strobe.
- R5: The count goes up by one with each strobe and saturates at 2^CNT_W-1. It holds its value after the transaction ends and returns to 0 on the next address cycle.
- R6: Error bit 0 is set when the initiator lowers ready or changes frame in the cycle after a data-phase cycle in which ready was high but the phase did not complete.
- R7: Error bit 1 is set when the target changes select, ready or stop in the cycle after a data-phase cycle in which target-ready or stop was high but the phase did not complete.
- R8: Error bit 2 is set when, during a transaction, frame falls from high to low in a cycle where initiator-ready is low. That cycle reads as idle.
- R9: Error bits are sticky. Later legal traffic leaves them set, and only reset clears them.
- R10: A data phase completes on initiator-ready together with target-ready or stop. A completion on stop alone releases both commitments and produces no strobe and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_frame | input | 1 | Initiator frame line, 1 = asserted |
| bus_irdy | input | 1 | Initiator ready, 1 = asserted |
| bus_trdy | input | 1 | Target ready, 1 = asserted |
| bus_stop | input | 1 | Target stop request, 1 = asserted |
| bus_devsel | input | 1 | Target select, 1 = asserted |
| phase_o | output | 2 | Phase of last sampled cycle: 0 idle, 1 address, 2 data |
| xfer_pulse_o | output | 1 | One-cycle strobe per moved data word |
| xfer_count_o | output | CNT_W | Words moved in the current or last transaction |
| err_o | output | 3 | Sticky errors: bit 0 initiator change, bit 1 target change, bit 2 illegal termination |

## Verification
The properties assume that reset is held for at least one edge before traffic starts, so that every registered output and the one-cycle history have defined values. They also assume the inputs are settled at each rising edge. The stimulus drives all bus lines on the falling edge and holds reset for several cycles at the start and around every directed case. Apart from that, the properties accept any bus activity, legal or not. The stimulus therefore mixes randomly timed legal transactions, with initiator and target wait states and stop-terminated phases, with deliberate violations that are each followed by a reset.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam int ERR_W    = 3;
    localparam int ERR_INIT = 0;
    localparam int ERR_TARG = 1;
    localparam int ERR_TERM = 2;

    typedef struct packed {
        logic frame;
        logic irdy;
        logic trdy;
        logic stop;
        logic devsel;
    } bus_s;

    // phase ends when the initiator is ready and the target answers
    function automatic logic phase_done(bus_s b);
        return b.irdy && (b.trdy || b.stop);
    endfunction

    // a data word moves only on a full two-sided ready
    function automatic logic word_moved(bus_s b);
        return b.irdy && b.trdy;
    endfunction

endpackage

// File: rtl/bhm_phase_tracker.sv
module bhm_phase_tracker
    import bhm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame,
    input  logic   irdy,
    output phase_e cls,
    output logic   busy,
    output phase_e phase_q
);

    logic busy_q;

    always_comb begin
        if (!busy_q) begin
            cls = frame ? PH_ADDR : PH_IDLE;
        end else if (!frame && !irdy) begin
            cls = PH_IDLE;
        end else begin
            cls = PH_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= PH_IDLE;
        end else begin
            busy_q  <= (cls != PH_IDLE);
            phase_q <= cls;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/bhm_commit_checker.sv
module bhm_commit_checker
    import bhm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_s             smp,
    input  logic             busy,
    input  phase_e           cls,
    output logic [ERR_W-1:0] err_q
);

    bus_s             prv_q;
    logic             init_held_q;
    logic             targ_held_q;
    logic [ERR_W-1:0] hit;
    logic             done;
    logic             in_data;

    assign done    = phase_done(smp);
    assign in_data = (cls == PH_DATA);

    always_comb begin
        hit           = '0;
        hit[ERR_INIT] = init_held_q && (!smp.irdy || (smp.frame != prv_q.frame));
        hit[ERR_TARG] = targ_held_q && ((smp.devsel != prv_q.devsel) ||
                                        (smp.trdy   != prv_q.trdy)   ||
                                        (smp.stop   != prv_q.stop));
        hit[ERR_TERM] = busy && prv_q.frame && !smp.frame && !smp.irdy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_q       <= '0;
            init_held_q <= 1'b0;
            targ_held_q <= 1'b0;
        end else begin
            prv_q       <= smp;
            init_held_q <= in_data && smp.irdy && !done;
            targ_held_q <= in_data && (smp.trdy || smp.stop) && !done;
        end
    end

    for (genvar g = 0; g < ERR_W; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) begin
                err_q[g] <= 1'b0;
            end else if (hit[g]) begin
                err_q[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bhm_xfer_counter.sv
module bhm_xfer_counter
    import bhm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           cls,
    input  logic             moved,
    output logic             pulse_q,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic beat;

    assign beat = (cls == PH_DATA) && moved;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            pulse_q <= beat;
            if (cls == PH_ADDR) begin
                cnt_q <= '0;
            end else if (beat && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bus_hs_monitor.sv
module bus_hs_monitor
    import bhm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_frame,
    input  logic             bus_irdy,
    input  logic             bus_trdy,
    input  logic             bus_stop,
    input  logic             bus_devsel,
    output logic [1:0]       phase_o,
    output logic             xfer_pulse_o,
    output logic [CNT_W-1:0] xfer_count_o,
    output logic [ERR_W-1:0] err_o
);

    bus_s   smp;
    phase_e cls;
    phase_e phase_q;
    logic   busy;

    assign smp = '{frame: bus_frame, irdy: bus_irdy, trdy: bus_trdy,
                   stop: bus_stop, devsel: bus_devsel};

    bhm_phase_tracker u_phase (
        .clk     (clk),
        .rst     (rst),
        .frame   (smp.frame),
        .irdy    (smp.irdy),
        .cls     (cls),
        .busy    (busy),
        .phase_q (phase_q)
    );

    bhm_commit_checker u_commit (
        .clk   (clk),
        .rst   (rst),
        .smp   (smp),
        .busy  (busy),
        .cls   (cls),
        .err_q (err_o)
    );

    bhm_xfer_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .cls     (cls),
        .moved   (word_moved(smp)),
        .pulse_q (xfer_pulse_o),
        .cnt_q   (xfer_count_o)
    );

    assign phase_o = phase_q;

endmodule

// File: rtl/bhm_checker.sv
module bhm_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_irdy,
    input logic             bus_trdy,
    input logic [1:0]       phase_o,
    input logic             xfer_pulse_o,
    input logic [CNT_W-1:0] xfer_count_o,
    input logic [2:0]       err_o
);

    // R4
    pulse_in_data_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_pulse_o |-> (phase_o == 2'd2));

    // R4
    pulse_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_pulse_o |-> $past(bus_irdy && bus_trdy));

    // R2
    addr_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1) |-> ($past(phase_o) == 2'd0));

    // R2
    addr_zero_count_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1) |-> (xfer_count_o == '0));

    // R3
    addr_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1) |=> (phase_o != 2'd1));

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase_o != 2'd1) && !xfer_pulse_o) |-> $stable(xfer_count_o));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(err_o) & ~err_o) == 3'b000));

endmodule

bind bus_hs_monitor bhm_checker #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_irdy     (bus_irdy),
    .bus_trdy     (bus_trdy),
    .phase_o      (phase_o),
    .xfer_pulse_o (xfer_pulse_o),
    .xfer_count_o (xfer_count_o),
    .err_o        (err_o)
);

// File: tb/bus_hs_monitor_tb_top.sv
module bus_hs_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;
    localparam int CMAX       = (1 << CW) - 1;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic f = 1'b0, i = 1'b0, t = 1'b0, s = 1'b0, d = 1'b0;
    logic [1:0]    phase_o;
    logic          xfer_pulse_o;
    logic [CW-1:0] xfer_count_o;
    logic [2:0]    err_o;

    int checks = 0;
    int errors = 0;

    // expected-state model built from the requirements
    int   m_phase, m_cnt;
    logic m_busy, m_ic, m_tc, m_pulse;
    logic [2:0] m_err;
    logic pf, pt, ps, pd;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_hs_monitor #(.CNT_W(CW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_frame    (f),
        .bus_irdy     (i),
        .bus_trdy     (t),
        .bus_stop     (s),
        .bus_devsel   (d),
        .phase_o      (phase_o),
        .xfer_pulse_o (xfer_pulse_o),
        .xfer_count_o (xfer_count_o),
        .err_o        (err_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_phase = 0; m_cnt = 0; m_busy = 0; m_ic = 0; m_tc = 0;
        m_pulse = 0; m_err = 0; pf = 0; pt = 0; ps = 0; pd = 0;
    endtask

    task automatic model_step();
        int   cls;
        logic done;
        if (!m_busy) cls = f ? 1 : 0;
        else         cls = (!f && !i) ? 0 : 2;
        if (m_ic && (!i || f != pf))               m_err[0] = 1'b1;
        if (m_tc && (d != pd || t != pt || s != ps)) m_err[1] = 1'b1;
        if (m_busy && pf && !f && !i)              m_err[2] = 1'b1;
        done    = i && (t || s);
        m_ic    = (cls == 2) && i && !done;
        m_tc    = (cls == 2) && (t || s) && !done;
        m_pulse = (cls == 2) && i && t;
        if (cls == 1)                     m_cnt = 0;
        else if (m_pulse && m_cnt < CMAX) m_cnt++;
        m_phase = cls;
        m_busy  = (cls != 0);
        pf = f; pt = t; ps = s; pd = d;
    endtask

    task automatic cyc(input logic nf, input logic ni, input logic nt,
                       input logic ns, input logic nd);
        f = nf; i = ni; t = nt; s = ns; d = nd;
        model_step();
        @(negedge clk);
        check((m_phase == 1) ? "R2" : "R3", "phase", int'(phase_o), m_phase);
        check("R4", "strobe", int'(xfer_pulse_o), int'(m_pulse));
        check("R5", "count", int'(xfer_count_o), m_cnt);
        check("R6", "err_init", int'(err_o[0]), int'(m_err[0]));
        check("R7", "err_targ", int'(err_o[1]), int'(m_err[1]));
        check("R8", "err_term", int'(err_o[2]), int'(m_err[2]));
    endtask

    task automatic do_reset();
        f = 0; i = 0; t = 0; s = 0; d = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "phase in reset", int'(phase_o), 0);
        check("R9", "errors cleared by reset", int'(err_o), 0);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check("R1", "phase after reset", int'(phase_o), 0);
        check("R1", "strobe after reset", int'(xfer_pulse_o), 0);
        check("R1", "count after reset", int'(xfer_count_o), 0);
    endtask

    task automatic rand_txn(input int nwords);
        cyc(1, 0, 0, 0, 0);
        for (int k = 0; k < nwords; k++) begin
            int   a, b, c;
            logic last, use_stop;
            last     = (k == nwords - 1);
            a        = $urandom_range(0, 2);
            b        = $urandom_range(0, 2);
            use_stop = ($urandom_range(0, 7) == 0);
            c        = (a > b) ? a : b;
            for (int j = 0; j <= c; j++) begin
                logic ii, tt;
                ii = (j >= a);
                tt = (j >= b);
                cyc(!(last && ii), ii, tt && !use_stop, tt && use_stop, 1'b1);
            end
        end
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_clear();
        @(negedge clk);
        do_reset();

        // zero-wait single word
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 1);
        check("R4", "single word strobe", int'(xfer_pulse_o), 1);
        cyc(0, 0, 0, 0, 0);
        check("R3", "back to idle", int'(phase_o), 0);
        check("R5", "count holds after end", int'(xfer_count_o), 1);

        // stop completion without transfer
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 1);
        check("R10", "stop gives no strobe", int'(xfer_pulse_o), 0);
        cyc(0, 0, 0, 0, 0);
        check("R10", "stop gives no count", int'(xfer_count_o), 0);
        check("R10", "no commit error after stop", int'(err_o), 0);

        // randomized legal traffic
        for (int n = 0; n < 40; n++) rand_txn($urandom_range(1, 5));
        check("R9", "no errors on legal traffic", int'(err_o), 0);

        // saturation
        cyc(1, 0, 0, 0, 0);
        for (int k = 0; k < 20; k++) cyc(k != 19, 1, 1, 0, 1);
        cyc(0, 0, 0, 0, 0);
        check("R5", "count saturates", int'(xfer_count_o), CMAX);
        cyc(1, 0, 0, 0, 0);
        check("R2", "address clears count", int'(xfer_count_o), 0);
        cyc(0, 1, 1, 0, 1);
        cyc(0, 0, 0, 0, 0);

        // initiator drops ready while committed
        do_reset();
        cyc(1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 1);
        cyc(1, 0, 0, 0, 1);
        check("R6", "initiator ready change", int'(err_o), 1);
        cyc(0, 1, 1, 0, 1);
        cyc(0, 0, 0, 0, 0);

        // initiator changes frame while committed
        do_reset();
        cyc(1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 1);
        cyc(0, 1, 1, 0, 1);
        check("R6", "initiator frame change", int'(err_o), 1);
        cyc(0, 0, 0, 0, 0);

        // target withdraws ready while committed
        do_reset();
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 1);
        cyc(1, 0, 0, 0, 1);
        check("R7", "target ready change", int'(err_o), 2);
        cyc(0, 1, 1, 0, 1);
        cyc(0, 0, 0, 0, 0);

        // illegal termination, then stickiness
        do_reset();
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        check("R8", "illegal termination", int'(err_o), 4);
        check("R8", "termination cycle idle", int'(phase_o), 0);
        rand_txn(3);
        check("R9", "error stays set", int'(err_o), 4);
        do_reset();
        check("R9", "reset clears error", int'(err_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule